// File: doc/BRIEF.md
# Double-Buffered Period-Match PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer with a selectable input prescaler. Below the timer sits a 2-bit sub-counter, which gives a 10-bit time base. The duty cycle is a 10-bit value, built from an 8-bit high part and a 2-bit low part. When the time base reaches the active duty value, the output falls. Each new period raises the output again, unless the active duty value is zero.

The host may rewrite the duty inputs at any time. The block copies them into a hidden shadow register only when a period begins. A period begins either when the timer wraps after matching the period value or when the enable is first asserted after reset. Because of this, a change never shortens or stretches the pulse already in progress. All inputs are plain control levels. There is no streaming data path and no handshake.

Top module: `pdb_pwm`

## Requirements
- R1: After the synchronous active-high reset the output is low and stays low while `run_en` has not yet been asserted.
- R2: A period lasts 4 × (`period_val` + 1) × N clock cycles, where N is 1 for `pre_sel` = 00, 4 for 01, and 16 for 10 or 11.
- R3: At the start of each period (the first enabled cycle after reset, and every wrap after the timer reaches `period_val`) the output goes high if the duty value latched at that moment is non-zero.
- R4: A latched duty value of zero keeps the output low for the whole period.
- R5: With latched duty D = {`duty_hi`, `duty_lo`} (`duty_hi` the upper 8 bits, `duty_lo` the lower 2 bits) and 0 < D < 4 × (`period_val` + 1), the output is high for exactly D × N cycles from the start of the period.
- R6: A change of `duty_hi`/`duty_lo` during a period does not alter that period's pulse. The new value takes effect from the next period.
- R7: A latched duty value of at least 4 × (`period_val` + 1) keeps the output high for the entire period.
- R8: While `run_en` is low after the block has started, the timer, the prescaler and the output all hold their values. Raising `run_en` again continues the period where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer enable; the first high cycle starts period one |
| period_val | input | 8 | Period register value |
| duty_hi | input | 8 | Upper 8 bits of the duty value |
| duty_lo | input | 2 | Lower 2 bits of the duty value |
| pre_sel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded properties rely on the period value and the prescale selection staying fixed within a period. They also take reset to be applied before the first enable. The directed stimulus changes `period_val` and `pre_sel` only while reset is held. Inside a running period it changes only the duty inputs and `run_en`, and the duty and enable changes are made on the falling clock edge. Under these conditions each period length and pulse width is an exact count of cycles.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int TMR_W = 8;
  localparam int SUB_W = 2;
  localparam int TB_W  = TMR_W + SUB_W;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10
  } ps_sel_e;

  // terminal count of the prescale counter for a selection (ratio - 1)
  function automatic logic [3:0] ps_last(input logic [1:0] sel);
    case (sel)
      PS_DIV1: ps_last = 4'd0;
      PS_DIV4: ps_last = 4'd3;
      default: ps_last = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/pdb_timebase.sv
module pdb_timebase
  import pdb_pkg::*;
#(
  parameter int TW  = TMR_W,
  parameter int SW  = SUB_W,
  parameter int PSW = 4,
  localparam int BW = TW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [TW-1:0] period_val,
  input  logic [1:0]    pre_sel,
  output logic [BW-1:0] tb,
  output logic          tick,
  output logic          wrap,
  output logic          start
);
  logic          started;
  logic [PSW-1:0] pc;
  logic [SW-1:0]  sub;
  logic [TW-1:0]  tmr;
  logic [PSW-1:0] lim;

  assign lim   = PSW'(ps_last(pre_sel));
  assign start = run_en && !started;
  assign tick  = run_en && started && (pc >= lim);
  assign wrap  = tick && (&sub) && (tmr >= period_val);
  assign tb    = {tmr, sub};

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      pc      <= '0;
      sub     <= '0;
      tmr     <= '0;
    end else if (start) begin
      started <= 1'b1;
    end else if (run_en && started) begin
      if (tick) begin
        pc  <= '0;
        sub <= sub + 1'b1;
        if (&sub) tmr <= wrap ? '0 : tmr + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (tb == '0));

  // R8
  freeze_tb_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !run_en) |=> $stable(tb));

  // R2
  ps_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pc == '0));
endmodule

// File: rtl/pdb_duty_buf.sv
module pdb_duty_buf #(
  parameter int DW = pdb_pkg::TB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] duty_in,
  output logic [DW-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (rst)       shadow <= '0;
    else if (load) shadow <= duty_in;
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shadow));
endmodule

// File: rtl/pdb_out.sv
module pdb_out #(
  parameter int DW = pdb_pkg::TB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          tick,
  input  logic [DW-1:0] duty_in,
  input  logic [DW-1:0] shadow,
  input  logic [DW-1:0] tb,
  output logic          pwm
);
  logic [DW:0] tb_next;

  assign tb_next = {1'b0, tb} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)
      pwm <= 1'b0;
    else if (load)
      pwm <= |duty_in;
    else if (tick && (tb_next == {1'b0, shadow}))
      pwm <= 1'b0;
  end

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (duty_in == '0)) |=> !pwm);

  // R3
  set_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (duty_in != '0)) |=> pwm);

  // R3
  rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm) |-> $past(load));
endmodule

// File: rtl/pdb_pwm.sv
module pdb_pwm
  import pdb_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int SW = SUB_W,
  localparam int DW = TW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [TW-1:0] period_val,
  input  logic [TW-1:0] duty_hi,
  input  logic [SW-1:0] duty_lo,
  input  logic [1:0]    pre_sel,
  output logic          pwm_out
);
  logic [DW-1:0] tb;
  logic [DW-1:0] shadow;
  logic [DW-1:0] duty_in;
  logic tick, wrap, start, load;

  assign duty_in = {duty_hi, duty_lo};
  assign load    = start | wrap;

  pdb_timebase #(.TW(TW), .SW(SW), .PSW(4)) u_tb (
    .clk(clk), .rst(rst), .run_en(run_en), .period_val(period_val),
    .pre_sel(pre_sel), .tb(tb), .tick(tick), .wrap(wrap), .start(start)
  );

  pdb_duty_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .load(load), .duty_in(duty_in), .shadow(shadow)
  );

  pdb_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .load(load), .tick(tick), .duty_in(duty_in),
    .shadow(shadow), .tb(tb), .pwm(pwm_out)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !pwm_out) |=> !pwm_out);
endmodule

// File: tb/sim_pdb_pwm.sv
module sim_pdb_pwm;
  logic clk = 1'b0;
  logic rst, run_en;
  logic [7:0] period_val, duty_hi;
  logic [1:0] duty_lo, pre_sel;
  logic pwm_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pdb_pwm u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .period_val(period_val),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .pre_sel(pre_sel), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] p, input logic [1:0] ps);
    @(negedge clk);
    rst = 1'b1; run_en = 1'b0; period_val = p; pre_sel = ps;
    duty_hi = 8'd0; duty_lo = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // sample n clocks at falling edges, return high count, first and last
  task automatic measure(input int n, output int highs, output int first, output int last);
    highs = 0; first = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      if (i == 0) first = int'(pwm_out);
      if (i == n - 1) last = int'(pwm_out);
    end
  endtask

  task automatic start_run(input logic [7:0] hi, input logic [1:0] lo);
    duty_hi = hi; duty_lo = lo; run_en = 1'b1;
  endtask

  task automatic t_reset;
    int h, f, l;
    do_reset(8'd2, 2'b00);
    chk(pwm_out == 1'b0, "R1 reset low", int'(pwm_out), 0);
    duty_hi = 8'd1;
    measure(6, h, f, l);
    chk(h == 0, "R1 idle before enable", h, 0);
  endtask

  // period 12, duty 5 (hi=1, lo=1) at 1:1
  task automatic t_basic;
    int h, f, l;
    do_reset(8'd2, 2'b00);
    start_run(8'd1, 2'd1);
    measure(12, h, f, l);
    chk(f == 1, "R3 high at start", f, 1);
    chk(h == 5, "R5 high time D=5", h, 5);
    chk(l == 0, "R2 low at period end", l, 0);
    measure(12, h, f, l);
    chk(f == 1, "R2 second period starts after 12", f, 1);
    chk(h == 5, "R5 second period high", h, 5);
  endtask

  task automatic t_lo_bits;
    int h, f, l;
    do_reset(8'd2, 2'b00);
    start_run(8'd1, 2'd2);
    measure(12, h, f, l);
    chk(h == 6, "R5 low bits D=6", h, 6);
  endtask

  task automatic t_zero;
    int h, f, l;
    do_reset(8'd2, 2'b00);
    start_run(8'd0, 2'd0);
    measure(24, h, f, l);
    chk(h == 0, "R4 zero duty stays low", h, 0);
  endtask

  task automatic t_over;
    int h, f, l;
    do_reset(8'd1, 2'b00);
    start_run(8'd3, 2'd0);
    measure(16, h, f, l);
    chk(h == 16, "R7 duty over period stays high", h, 16);
  endtask

  task automatic t_dbuf;
    int h1, h2, f, l;
    do_reset(8'd3, 2'b00);
    start_run(8'd1, 2'd0);
    measure(2, h1, f, l);
    duty_hi = 8'd2; duty_lo = 2'd2;
    measure(14, h2, f, l);
    chk(h1 + h2 == 4, "R6 current period keeps old duty", h1 + h2, 4);
    measure(16, h2, f, l);
    chk(h2 == 10, "R6 new duty next period", h2, 10);
  endtask

  task automatic t_pre4;
    int h, f, l;
    do_reset(8'd1, 2'b01);
    start_run(8'd0, 2'd3);
    measure(32, h, f, l);
    chk(h == 12, "R5 high time at 1:4", h, 12);
    chk(l == 0, "R2 low at end 1:4", l, 0);
    measure(1, h, f, l);
    chk(f == 1, "R2 period 32 at 1:4", f, 1);
  endtask

  task automatic t_pre16;
    int h, f, l;
    do_reset(8'd0, 2'b11);
    start_run(8'd0, 2'd1);
    measure(64, h, f, l);
    chk(h == 16, "R5 high time at 1:16", h, 16);
    measure(1, h, f, l);
    chk(f == 1, "R2 period 64 at 1:16", f, 1);
  endtask

  task automatic t_freeze;
    int h, f, l;
    do_reset(8'd3, 2'b00);
    start_run(8'd2, 2'd0);
    measure(3, h, f, l);
    run_en = 1'b0;
    measure(10, h, f, l);
    chk(h == 10, "R8 output held while disabled", h, 10);
    run_en = 1'b1;
    measure(13, h, f, l);
    chk(h == 5, "R8 period resumes", h, 5);
    measure(1, h, f, l);
    chk(f == 1, "R8 next period on time", f, 1);
  endtask

  initial begin
    rst = 1'b1; run_en = 1'b0; period_val = '0; duty_hi = '0;
    duty_lo = '0; pre_sel = '0;
    t_reset();
    t_basic();
    t_lo_bits();
    t_zero();
    t_over();
    t_dbuf();
    t_pre4();
    t_pre16();
    t_freeze();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule